// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Controller

This unit sits next to a simple in-order fetch stage and steers its program counter through hardware loops, so no branch instruction is needed to close a loop. Software programs up to four loop descriptors. Each descriptor holds a body start address, a body end address, an exit target and a 16-bit trip count. A loop is activated by an enter request. From then on the controller compares every fetched PC with the end address of the innermost active loop. While passes remain, it redirects fetch back to the body start in the same cycle, so the wrap costs no bubble.

Active loops form a stack of descriptor numbers. Because of this, any descriptor can be nested inside any other. When an inner loop finishes, fetch falls through past its end and stays inside the enclosing body. A runtime exit flag abandons the innermost loop and sends fetch to that loop's exit target. A runtime jump request swaps the innermost loop for a different descriptor. A descriptor whose count is zero is skipped: fetch lands on the instruction after its end. Hazards between iterations are left to software.

Exactly one event is acted on per cycle, in this priority order: exit, jump, enter, end match.

Top module: `nloop_top`

## Requirements
- R1: While reset is held and after it is released, the depth, the reported top level and the reported top count are all 0, and no redirect is issued unless an enter request arrives.
- R2: A valid fetch whose PC equals the innermost loop's end address, with a live count above 1, redirects fetch to that loop's start address in the same cycle. The live count drops by one and the depth is unchanged.
- R3: The same end match with a live count of exactly 1 issues no redirect, so fetch falls through. The loop is popped and its live count is reloaded with its programmed count.
- R4: An enter request with depth below 4 and a nonzero programmed count redirects to that level's start address in the same cycle, pushes the level and loads its live count. A count of N makes the end address fetch N times. A configuration write sets a level's addresses and count and also loads its live count.
- R5: The depth, the top level and the top count follow the loop stack. After an inner loop pops, the enclosing level is reported again with the live count it had before the inner loop ran.
- R6: When the exit flag is high and depth is above 0, fetch is redirected to the innermost loop's exit target and that loop is popped. The exit flag overrides jump, enter and the end match.
- R7: A jump request with depth above 0 and a nonzero target count replaces the innermost loop with the target level. It redirects to the target's start address and loads the target's live count. When the target completes, fetch falls through inside the former parent.
- R8: An enter or jump request naming a level with count 0 redirects to that level's end address plus 1 and pushes nothing. A jump still removes the loop it left.
- R9: These requests are ignored, with no redirect and no change of state: enter at depth 4, and jump or exit at depth 0.
- R10: With the fetch valid input low, an end-address match is ignored. No redirect is issued without a valid fetch or a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write one loop descriptor |
| cfgLevel | input | 2 | Descriptor number to write |
| cfgStart | input | PC_W | Body start address |
| cfgEnd | input | PC_W | Body end address (last body instruction) |
| cfgExit | input | PC_W | Exit target address |
| cfgCount | input | CNT_W | Trip count, 0 means skip |
| fetchValid | input | 1 | Fetch stage presents a PC this cycle |
| fetchPc | input | PC_W | PC being fetched |
| enterReq | input | 1 | Activate a descriptor as a new inner loop |
| enterLevel | input | 2 | Descriptor to activate |
| jumpReq | input | 1 | Replace the innermost loop with another descriptor |
| jumpLevel | input | 2 | Jump target descriptor |
| exitCond | input | 1 | Runtime early-exit flag for the innermost loop |
| redirectValid | output | 1 | Fetch must continue at redirectPc |
| redirectPc | output | PC_W | Next fetch address when redirecting |
| loopDepth | output | 3 | Number of active loops |
| topLevel | output | 2 | Descriptor of the innermost loop (0 when idle) |
| topCount | output | CNT_W | Live count of the innermost loop (0 when idle) |

## Verification
The redirect decision and its target are combinational, so they are due in the same cycle as the fetch PC or request that causes them. The bench samples them two nanoseconds after driving, before the next rising edge. Depth, top level and top count come from registers, so they reflect an event one cycle later. The bench's queue-based model therefore updates its own state only after comparing the current outputs, and compares the new state at the next sample point. The model's redirect, not the design's, advances the bench's fetch PC, which keeps the pass counts for the trip-count and nesting requirements independent of the design.

// File: rtl/nloop_pkg.sv
package nloop_pkg;
  localparam int NL_LEVELS = 4;
  localparam int NL_PCW    = 32;
  localparam int NL_CNTW   = 16;
  localparam int NL_LVLW   = $clog2(NL_LEVELS);
  localparam int NL_DEPW   = $clog2(NL_LEVELS + 1);

  typedef enum logic [1:0] {
    PC_HOLD    = 2'd0,
    PC_START   = 2'd1,
    PC_EXIT    = 2'd2,
    PC_PASTEND = 2'd3
  } pcSel_e;

  // control -> datapath strobes for one cycle
  typedef struct packed {
    logic                reload;
    logic                dec;
    logic [NL_LVLW-1:0]  lvl;
    pcSel_e              pcSel;
  } nlStrobe_t;
endpackage

// File: rtl/nloop_levels.sv
module nloop_levels
  import nloop_pkg::*;
#(
  parameter int PC_W  = NL_PCW,
  parameter int CNT_W = NL_CNTW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [NL_LVLW-1:0] cfgLevel,
  input  logic [PC_W-1:0]    cfgStart,
  input  logic [PC_W-1:0]    cfgEnd,
  input  logic [PC_W-1:0]    cfgExit,
  input  logic [CNT_W-1:0]   cfgCount,
  input  nlStrobe_t          strobe,
  input  logic [PC_W-1:0]    fetchPc,
  input  logic               hasTop,
  input  logic [NL_LVLW-1:0] topLvl,
  output logic [NL_LEVELS-1:0] endHit,
  output logic [NL_LEVELS-1:0] lastPass,
  output logic [NL_LEVELS-1:0] initZero,
  output logic               redirectValid,
  output logic [PC_W-1:0]    redirectPc,
  output logic [CNT_W-1:0]   topCount
);
  logic [PC_W-1:0]  startPc [NL_LEVELS];
  logic [PC_W-1:0]  endPc   [NL_LEVELS];
  logic [PC_W-1:0]  exitPc  [NL_LEVELS];
  logic [CNT_W-1:0] initCnt [NL_LEVELS];
  logic [CNT_W-1:0] liveCnt [NL_LEVELS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NL_LEVELS; i++) begin
        startPc[i] <= '0;
        endPc[i]   <= '0;
        exitPc[i]  <= '0;
        initCnt[i] <= '0;
        liveCnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NL_LEVELS; i++) begin
        if (cfgWe && cfgLevel == NL_LVLW'(i)) begin
          startPc[i] <= cfgStart;
          endPc[i]   <= cfgEnd;
          exitPc[i]  <= cfgExit;
          initCnt[i] <= cfgCount;
          liveCnt[i] <= cfgCount;
        end else if (strobe.lvl == NL_LVLW'(i)) begin
          if (strobe.reload)   liveCnt[i] <= initCnt[i];
          else if (strobe.dec) liveCnt[i] <= liveCnt[i] - 1'b1;
        end
      end
    end
  end

  // per-level compare flags for the control
  for (genvar g = 0; g < NL_LEVELS; g++) begin : gLevel
    assign endHit[g]   = (fetchPc == endPc[g]);
    assign lastPass[g] = (liveCnt[g] == CNT_W'(1));
    assign initZero[g] = (initCnt[g] == '0);
  end

  always_comb begin
    redirectValid = (strobe.pcSel != PC_HOLD);
    case (strobe.pcSel)
      PC_START:   redirectPc = startPc[strobe.lvl];
      PC_EXIT:    redirectPc = exitPc[strobe.lvl];
      PC_PASTEND: redirectPc = endPc[strobe.lvl] + 1'b1;
      default:    redirectPc = '0;
    endcase
  end

  assign topCount = hasTop ? liveCnt[topLvl] : '0;
endmodule

// File: rtl/nloop_ctrl.sv
module nloop_ctrl
  import nloop_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fetchValid,
  input  logic                 enterReq,
  input  logic [NL_LVLW-1:0]   enterLevel,
  input  logic                 jumpReq,
  input  logic [NL_LVLW-1:0]   jumpLevel,
  input  logic                 exitCond,
  input  logic [NL_LEVELS-1:0] endHit,
  input  logic [NL_LEVELS-1:0] lastPass,
  input  logic [NL_LEVELS-1:0] initZero,
  output nlStrobe_t            strobe,
  output logic [NL_DEPW-1:0]   depth,
  output logic [NL_LVLW-1:0]   topLvl,
  output logic                 hasTop
);
  logic [NL_LVLW-1:0] stackQ [NL_LEVELS];
  logic [NL_DEPW-1:0] depthQ;
  logic [NL_LVLW-1:0] topIdx;
  logic               full, pushEn, popEn, replaceEn;

  assign hasTop = (depthQ != '0);
  assign full   = (depthQ == NL_DEPW'(NL_LEVELS));
  assign topIdx = NL_LVLW'(depthQ - 1'b1);
  assign topLvl = hasTop ? stackQ[topIdx] : '0;
  assign depth  = depthQ;

  // one event per cycle: exit > jump > enter > end match
  always_comb begin
    strobe    = '0;
    pushEn    = 1'b0;
    popEn     = 1'b0;
    replaceEn = 1'b0;
    if (hasTop && exitCond) begin
      strobe.lvl   = topLvl;
      strobe.pcSel = PC_EXIT;
      popEn        = 1'b1;
    end else if (hasTop && jumpReq) begin
      strobe.lvl = jumpLevel;
      if (initZero[jumpLevel]) begin
        strobe.pcSel = PC_PASTEND;
        popEn        = 1'b1;
      end else begin
        strobe.pcSel  = PC_START;
        strobe.reload = 1'b1;
        replaceEn     = 1'b1;
      end
    end else if (enterReq && !full) begin
      strobe.lvl = enterLevel;
      if (initZero[enterLevel]) begin
        strobe.pcSel = PC_PASTEND;
      end else begin
        strobe.pcSel  = PC_START;
        strobe.reload = 1'b1;
        pushEn        = 1'b1;
      end
    end else if (hasTop && fetchValid && endHit[topLvl]) begin
      strobe.lvl = topLvl;
      if (lastPass[topLvl]) begin
        strobe.reload = 1'b1;
        popEn         = 1'b1;
      end else begin
        strobe.dec   = 1'b1;
        strobe.pcSel = PC_START;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthQ <= '0;
      for (int i = 0; i < NL_LEVELS; i++) stackQ[i] <= '0;
    end else if (pushEn) begin
      stackQ[NL_LVLW'(depthQ)] <= strobe.lvl;
      depthQ <= depthQ + 1'b1;
    end else if (replaceEn) begin
      stackQ[topIdx] <= strobe.lvl;
    end else if (popEn) begin
      depthQ <= depthQ - 1'b1;
    end
  end
endmodule

// File: rtl/nloop_top.sv
module nloop_top
  import nloop_pkg::*;
#(
  parameter int PC_W  = NL_PCW,
  parameter int CNT_W = NL_CNTW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [NL_LVLW-1:0] cfgLevel,
  input  logic [PC_W-1:0]    cfgStart,
  input  logic [PC_W-1:0]    cfgEnd,
  input  logic [PC_W-1:0]    cfgExit,
  input  logic [CNT_W-1:0]   cfgCount,
  input  logic               fetchValid,
  input  logic [PC_W-1:0]    fetchPc,
  input  logic               enterReq,
  input  logic [NL_LVLW-1:0] enterLevel,
  input  logic               jumpReq,
  input  logic [NL_LVLW-1:0] jumpLevel,
  input  logic               exitCond,
  output logic               redirectValid,
  output logic [PC_W-1:0]    redirectPc,
  output logic [NL_DEPW-1:0] loopDepth,
  output logic [NL_LVLW-1:0] topLevel,
  output logic [CNT_W-1:0]   topCount
);
  nlStrobe_t            strobe;
  logic [NL_LEVELS-1:0] endHit, lastPass, initZero;
  logic                 hasTop;

  nloop_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid),
    .enterReq(enterReq), .enterLevel(enterLevel),
    .jumpReq(jumpReq), .jumpLevel(jumpLevel), .exitCond(exitCond),
    .endHit(endHit), .lastPass(lastPass), .initZero(initZero),
    .strobe(strobe), .depth(loopDepth), .topLvl(topLevel), .hasTop(hasTop)
  );

  nloop_levels #(.PC_W(PC_W), .CNT_W(CNT_W)) uLevels (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgLevel(cfgLevel),
    .cfgStart(cfgStart), .cfgEnd(cfgEnd), .cfgExit(cfgExit), .cfgCount(cfgCount),
    .strobe(strobe), .fetchPc(fetchPc), .hasTop(hasTop), .topLvl(topLevel),
    .endHit(endHit), .lastPass(lastPass), .initZero(initZero),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .topCount(topCount)
  );
endmodule

// File: rtl/nloop_checker.sv
module nloop_checker
  import nloop_pkg::*;
#(
  parameter int PC_W  = NL_PCW,
  parameter int CNT_W = NL_CNTW
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgWe,
  input logic [NL_LVLW-1:0] cfgLevel,
  input logic [PC_W-1:0]    cfgStart,
  input logic [PC_W-1:0]    cfgEnd,
  input logic [PC_W-1:0]    cfgExit,
  input logic [CNT_W-1:0]   cfgCount,
  input logic               fetchValid,
  input logic [PC_W-1:0]    fetchPc,
  input logic               enterReq,
  input logic [NL_LVLW-1:0] enterLevel,
  input logic               jumpReq,
  input logic [NL_LVLW-1:0] jumpLevel,
  input logic               exitCond,
  input logic               redirectValid,
  input logic [PC_W-1:0]    redirectPc,
  input logic [NL_DEPW-1:0] loopDepth,
  input logic [NL_LVLW-1:0] topLevel,
  input logic [CNT_W-1:0]   topCount
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (loopDepth == '0 && !enterReq) |-> !redirectValid);

  assert_wrap_dec_R2: assert property (@(posedge clk) disable iff (!rstN)
    (loopDepth != '0 && redirectValid && !exitCond && !jumpReq && !enterReq && !cfgWe)
    |=> (loopDepth == $past(loopDepth) && topCount == CNT_W'($past(topCount) - 1'b1)));

  assert_exit_redirect_R6: assert property (@(posedge clk) disable iff (!rstN)
    (loopDepth != '0 && exitCond) |-> redirectValid);

  assert_exit_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (loopDepth != '0 && exitCond) |=> loopDepth == NL_DEPW'($past(loopDepth) - 1'b1));

  assert_jump_redirect_R7: assert property (@(posedge clk) disable iff (!rstN)
    (loopDepth != '0 && !exitCond && jumpReq) |-> redirectValid);

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    enterReq |=> loopDepth <= NL_DEPW'(NL_LEVELS));

  assert_full_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (loopDepth == NL_DEPW'(NL_LEVELS) && enterReq && !exitCond && !jumpReq && !fetchValid)
    |-> !redirectValid);

  assert_no_fetch_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchValid && !exitCond && !jumpReq && !enterReq) |-> !redirectValid);
endmodule

bind nloop_top nloop_checker #(.PC_W(PC_W), .CNT_W(CNT_W)) uChecker (.*);

// File: tb/nloop_top_test.sv
module nloop_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgLevel = '0;
  logic [31:0] cfgStart = '0, cfgEnd = '0, cfgExit = '0;
  logic [15:0] cfgCount = '0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        enterReq = 1'b0, jumpReq = 1'b0, exitCond = 1'b0;
  logic [1:0]  enterLevel = '0, jumpLevel = '0;
  logic        redirectValid;
  logic [31:0] redirectPc;
  logic [2:0]  loopDepth;
  logic [1:0]  topLevel;
  logic [15:0] topCount;

  nloop_top uut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  // behavioural reference state
  int mStart[4], mEnd[4], mExit[4], mInit[4], mLive[4];
  int stk[$];
  bit expRv;
  int expPc;
  // run-loop trigger
  int trigPc = -1, trigKind = 0, trigLvl = 0, trigSkip = 0;
  bit trigOnce = 0;
  int watchA = -1, watchB = -1, hitsA = 0, hitsB = 0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare this cycle, then advance the model across the edge
  task automatic step();
    int d, top, jl, el, pc;
    bit rv;
    string tag;
    #2;
    d = stk.size();
    top = (d > 0) ? stk[d-1] : 0;
    check(loopDepth == d, "R5 depth", loopDepth, d);
    check(topLevel == top, "R5 topLevel", topLevel, top);
    check(topCount == ((d > 0) ? mLive[top] : 0), "R5 topCount", topCount, (d > 0) ? mLive[top] : 0);
    rv = 0; pc = 0; tag = "R10";
    jl = int'(jumpLevel); el = int'(enterLevel);
    if (d > 0 && exitCond) begin
      tag = "R6"; rv = 1; pc = mExit[top]; void'(stk.pop_back());
    end else if (d > 0 && jumpReq) begin
      rv = 1;
      if (mInit[jl] == 0) begin tag = "R8"; pc = mEnd[jl] + 1; void'(stk.pop_back()); end
      else begin tag = "R7"; pc = mStart[jl]; mLive[jl] = mInit[jl]; stk[d-1] = jl; end
    end else if (enterReq && d < 4) begin
      rv = 1;
      if (mInit[el] == 0) begin tag = "R8"; pc = mEnd[el] + 1; end
      else begin tag = "R4"; pc = mStart[el]; mLive[el] = mInit[el]; stk.push_back(el); end
    end else if (d > 0 && fetchValid && fetchPc == 32'(mEnd[top])) begin
      if (mLive[top] == 1) begin tag = "R3"; mLive[top] = mInit[top]; void'(stk.pop_back()); end
      else begin tag = "R2"; rv = 1; pc = mStart[top]; mLive[top]--; end
    end else if (exitCond || jumpReq || enterReq) begin
      tag = "R9";
    end
    check(redirectValid == rv, {tag, " redirectValid"}, redirectValid, rv);
    if (rv) check(redirectPc == 32'(pc), {tag, " redirectPc"}, redirectPc, pc);
    if (cfgWe) begin
      mStart[cfgLevel] = int'(cfgStart); mEnd[cfgLevel] = int'(cfgEnd);
      mExit[cfgLevel] = int'(cfgExit); mInit[cfgLevel] = int'(cfgCount);
      mLive[cfgLevel] = int'(cfgCount);
    end
    expRv = rv; expPc = pc;
    @(negedge clk);
  endtask

  task automatic cfg(int l, int s, int e, int x, int c);
    cfgWe = 1; cfgLevel = 2'(l); cfgStart = 32'(s); cfgEnd = 32'(e);
    cfgExit = 32'(x); cfgCount = 16'(c);
    step();
    cfgWe = 0;
  endtask

  task automatic cmd(int kind, int lvl, bit fv, int pc);
    fetchValid = fv; fetchPc = 32'(pc);
    enterReq = (kind == 1); jumpReq = (kind == 2); exitCond = (kind == 3);
    enterLevel = 2'(lvl); jumpLevel = 2'(lvl);
    step();
    enterReq = 0; jumpReq = 0; exitCond = 0; fetchValid = 0;
  endtask

  // fetch walks forward, following the model's redirects
  task automatic run(int startPc, int stopPc, int maxCyc);
    int pc = startPc;
    hitsA = 0; hitsB = 0;
    for (int c = 0; c < maxCyc; c++) begin
      fetchValid = 1; fetchPc = 32'(pc);
      if (pc == watchA) hitsA++;
      if (pc == watchB) hitsB++;
      if (trigKind != 0 && pc == trigPc) begin
        if (trigSkip > 0) trigSkip--;
        else begin
          enterReq = (trigKind == 1); jumpReq = (trigKind == 2); exitCond = (trigKind == 3);
          enterLevel = 2'(trigLvl); jumpLevel = 2'(trigLvl);
          if (trigOnce) trigKind = 0;
        end
      end
      step();
      enterReq = 0; jumpReq = 0; exitCond = 0;
      pc = expRv ? expPc : pc + 1;
      if (pc == stopPc) break;
    end
    fetchValid = 0;
  endtask

  task automatic setTrig(int kind, int pc, int lvl, int skip, bit once);
    trigKind = kind; trigPc = pc; trigLvl = lvl; trigSkip = skip; trigOnce = once;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      mStart[i] = 0; mEnd[i] = 0; mExit[i] = 0; mInit[i] = 0; mLive[i] = 0;
    end
    @(negedge clk); @(negedge clk);
    #2;
    check(loopDepth == 0 && topCount == 0 && !redirectValid, "R1 in reset", loopDepth, 0);
    @(negedge clk);
    rstN = 1;
    step();
    step();

    // R4 single loop, count 3
    cfg(0, 10, 13, 100, 3);
    cmd(1, 0, 1, 9);
    watchA = 13; watchB = -1;
    run(10, 14, 40);
    check(hitsA == 3, "R4 end fetches", hitsA, 3);
    check(stk.size() == 0 && loopDepth == 0, "R3 popped", loopDepth, 0);

    // R5 nesting: outer 2, inner 3
    cfg(0, 20, 30, 100, 2);
    cfg(1, 22, 24, 101, 3);
    cmd(1, 0, 1, 19);
    setTrig(1, 21, 1, 0, 0);
    watchA = 24; watchB = 30;
    run(20, 31, 100);
    setTrig(0, -1, 0, 0, 0);
    check(hitsA == 6, "R5 inner end fetches", hitsA, 6);
    check(hitsB == 2, "R5 outer end fetches", hitsB, 2);
    check(loopDepth == 0, "R5 depth after", loopDepth, 0);

    // R10 end match without valid fetch, then R6 clean exit
    cfg(0, 10, 13, 100, 3);
    cmd(1, 0, 1, 9);
    cmd(0, 0, 0, 13);
    cmd(0, 0, 0, 13);
    check(topCount == 3, "R10 count kept", topCount, 3);
    cmd(3, 0, 0, 0);

    // R6 exit on the end address of the second pass
    cfg(0, 40, 45, 60, 5);
    cmd(1, 0, 1, 39);
    setTrig(3, 45, 0, 1, 1);
    watchA = 45; watchB = 60;
    run(40, 61, 60);
    check(hitsA == 2 && hitsB == 1, "R6 exit path", hitsA * 10 + hitsB, 21);
    check(loopDepth == 0, "R6 depth", loopDepth, 0);

    // R7 jump from inner loop to an unrelated loop
    cfg(0, 50, 60, 99, 2);
    cfg(1, 52, 54, 98, 4);
    cfg(2, 70, 72, 97, 2);
    cmd(1, 0, 1, 49);
    setTrig(1, 51, 1, 0, 1);
    run(50, 53, 10);
    setTrig(2, 53, 2, 0, 1);
    watchA = 72; watchB = -1;
    run(53, 73, 20);
    check(hitsA == 2, "R7 target passes", hitsA, 2);
    check(loopDepth == 1 && topLevel == 0 && topCount == 2, "R7 back in parent", topCount, 2);
    cmd(3, 0, 0, 0);

    // R8 zero count on enter and on jump
    cfg(3, 80, 85, 96, 0);
    cmd(1, 3, 1, 79);
    check(loopDepth == 0, "R8 no push", loopDepth, 0);
    cmd(1, 2, 1, 69);
    cmd(2, 3, 1, 70);
    check(loopDepth == 0, "R8 jump removes", loopDepth, 0);

    // R9 ignored requests
    cmd(3, 0, 0, 0);
    cmd(2, 1, 0, 0);
    cfg(3, 80, 85, 96, 7);
    for (int l = 0; l < 4; l++) cmd(1, l, 0, 0);
    check(loopDepth == 4, "R9 full", loopDepth, 4);
    cmd(1, 0, 0, 0);
    check(loopDepth == 4 && topLevel == 3, "R9 full ignore", loopDepth, 4);
    for (int l = 0; l < 4; l++) cmd(3, 0, 0, 0);
    check(loopDepth == 0, "R6 drained", loopDepth, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule